// File: doc/BRIEF.md
# Serial Identity CRC-8 Engine

This block computes and verifies the 8-bit cyclic redundancy code that protects a 64-bit device identity. The identity has three fields: an 8-bit family code, then a 48-bit serial number, then the CRC byte. The identity is fed into the block one bit per accepted transfer, least significant bit first, starting with the family code.

The block has two modes, chosen when a run is cleared. In generate mode it takes the first 56 bits and then holds the resulting CRC byte on its output. In check mode it takes all 64 bits. A correct identity leaves the register at zero, and the block then raises its identity-good flag.

Bits enter on a valid/ready stream. A bit transfers on a rising clock edge where `bit_valid` and `bit_ready` are both high. A producer may hold `bit_valid` low for any number of cycles between bits. `bit_ready` drops once the run has taken its full count of bits, and it stays low until the next clear. While `bit_ready` is low, an offered bit stays pending at the source and is never consumed. The clear, mode, CRC, done and identity-good signals are plain level pins.

Top module: `sid_crc8`

## Requirements
- R1: After reset, `crc_value` is 0x00, `run_done` and `id_good` are 0, `bit_ready` is 1, and the mode is generate.
- R2: Each accepted bit updates the register as follows. Compute f = bit XOR register[0]. Shift the register right by one. If f is 1, XOR in 0x8C. This is the reflected form of x^8+x^5+x^4+1. The new value appears on `crc_value` in the cycle after the accepting edge.
- R3: Bits are used in the order they are accepted. If the 8 family bits and then the 48 serial bits are sent, each field LSB first, `crc_value` then equals the CRC of those 56 bits under x^8+x^5+x^4+1, starting from a zero register.
- R4: In generate mode (`mode_check`=0 at clear), `run_done` rises in the cycle after the 56th accepted bit. `crc_value` then holds its value.
- R5: In check mode (`mode_check`=1 at clear), `run_done` rises in the cycle after the 64th accepted bit. A correct identity leaves `crc_value` at 0x00, and any single-bit error leaves it nonzero.
- R6: While `run_done` is 1, `bit_ready` is 0 and offered bits have no effect on `crc_value`.
- R7: `id_good` is 1 only when `run_done` is 1, the mode is check, and `crc_value` is 0x00. In generate mode it stays 0 even when the CRC is 0x00.
- R8: `clear` is synchronous. It zeros the register and the bit count, clears `run_done`, and captures `mode_check` as the mode. It takes priority over a bit offered in the same cycle.
- R9: In a cycle with no accepted bit and no clear, `crc_value` and `run_done` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Synchronous restart of a run |
| mode_check | input | 1 | Mode captured at clear: 0 generate, 1 check |
| bit_valid | input | 1 | Producer offers `bit_in` |
| bit_ready | output | 1 | Block can accept a bit |
| bit_in | input | 1 | Serial identity bit |
| crc_value | output | 8 | Current CRC register |
| run_done | output | 1 | Run has taken its full count of bits |
| id_good | output | 1 | Checked identity has a zero residue |

## Verification
Every result is due in the cycle after the accepting edge: the register update, the rise of `run_done`, and the `id_good` verdict. The bench drives inputs on falling edges and samples on the next falling edge after the edge that mattered, so each check lands one register stage after its stimulus. The sweep covers every family code in both modes, with good and corrupted CRC bytes and with idle gaps inside runs. Because the gaps must not change any result, the sweep also checks that timing does not matter.

// File: rtl/sid_crc_pkg.sv
package sid_crc_pkg;
  localparam int FAMILY_BITS = 8;
  localparam int SERIAL_BITS = 48;
  localparam int CODE_BITS   = 8;
  localparam logic [CODE_BITS-1:0] TAPS_REFLECTED = 8'h8C;

  typedef enum logic {
    RUN_GENERATE = 1'b0,
    RUN_CHECK    = 1'b1
  } run_mode_e;
endpackage

// File: rtl/sid_crc_shift.sv
module sid_crc_shift #(
  parameter int W = 8,
  parameter logic [W-1:0] TAPS = 8'h8C
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         step,
  input  logic         din,
  output logic [W-1:0] crc
);
  logic         fold;
  logic [W-1:0] next_crc;

  assign fold = din ^ crc[0];

  for (genvar i = 0; i < W; i++) begin : g_tap
    if (i == W - 1) begin : g_top
      assign next_crc[i] = fold & TAPS[i];
    end else begin : g_mid
      assign next_crc[i] = crc[i+1] ^ (fold & TAPS[i]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc <= '0;
    end else if (clear) begin
      crc <= '0;
    end else if (step) begin
      crc <= next_crc;
    end
  end
endmodule

// File: rtl/sid_bit_tally.sv
module sid_bit_tally
  import sid_crc_pkg::*;
#(
  parameter int GEN_LEN = 56,
  parameter int CHK_LEN = 64,
  localparam int CW = $clog2(CHK_LEN + 1)
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      clear,
  input  run_mode_e mode_in,
  input  logic      step,
  output run_mode_e mode_q,
  output logic      done
);
  logic [CW-1:0] count;
  logic [CW-1:0] target;

  assign target = (mode_q == RUN_CHECK) ? CW'(CHK_LEN) : CW'(GEN_LEN);
  assign done   = (count == target);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count  <= '0;
      mode_q <= RUN_GENERATE;
    end else if (clear) begin
      count  <= '0;
      mode_q <= mode_in;
    end else if (step && !done) begin
      count <= count + CW'(1);
    end
  end
endmodule

// File: rtl/sid_crc_verdict.sv
module sid_crc_verdict
  import sid_crc_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         done,
  input  run_mode_e    mode,
  input  logic [W-1:0] crc,
  output logic         good
);
  assign good = done && (mode == RUN_CHECK) && (crc == '0);
endmodule

// File: rtl/sid_crc8.sv
module sid_crc8
  import sid_crc_pkg::*;
#(
  parameter int FAM_W = FAMILY_BITS,
  parameter int SER_W = SERIAL_BITS,
  parameter int CRC_W = CODE_BITS,
  parameter logic [CRC_W-1:0] TAPS = TAPS_REFLECTED,
  localparam int GEN_LEN = FAM_W + SER_W,
  localparam int CHK_LEN = GEN_LEN + CRC_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             mode_check,
  input  logic             bit_valid,
  output logic             bit_ready,
  input  logic             bit_in,
  output logic [CRC_W-1:0] crc_value,
  output logic             run_done,
  output logic             id_good
);
  run_mode_e mode_q;
  logic      take;

  assign bit_ready = ~run_done;
  assign take      = bit_valid & bit_ready & ~clear;

  sid_crc_shift #(.W(CRC_W), .TAPS(TAPS)) u_shift (
    .clk  (clk),
    .rst_n(rst_n),
    .clear(clear),
    .step (take),
    .din  (bit_in),
    .crc  (crc_value)
  );

  sid_bit_tally #(.GEN_LEN(GEN_LEN), .CHK_LEN(CHK_LEN)) u_tally (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (clear),
    .mode_in(run_mode_e'(mode_check)),
    .step   (take),
    .mode_q (mode_q),
    .done   (run_done)
  );

  sid_crc_verdict #(.W(CRC_W)) u_verdict (
    .done(run_done),
    .mode(mode_q),
    .crc (crc_value),
    .good(id_good)
  );
endmodule

// File: rtl/sid_crc8_checks.sv
module sid_crc8_checks #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         clear,
  input logic         bit_valid,
  input logic         bit_ready,
  input logic [W-1:0] crc_value,
  input logic         run_done,
  input logic         id_good
);
  a_r6_no_ready_when_done: assert property (@(posedge clk) disable iff (!rst_n)
    run_done |-> !bit_ready);

  a_r7_good_needs_zero_done: assert property (@(posedge clk) disable iff (!rst_n)
    id_good |-> (run_done && crc_value == '0));

  a_r8_clear_zeros: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (crc_value == '0 && !run_done && !id_good));

  a_r9_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !(bit_valid && bit_ready)) |=> ($stable(crc_value) && $stable(run_done)));

  a_r4_done_after_take: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_done) |-> $past(bit_valid && bit_ready && !clear));
endmodule

bind sid_crc8 sid_crc8_checks #(.W(CRC_W)) u_checks (
  .clk      (clk),
  .rst_n    (rst_n),
  .clear    (clear),
  .bit_valid(bit_valid),
  .bit_ready(bit_ready),
  .crc_value(crc_value),
  .run_done (run_done),
  .id_good  (id_good)
);

// File: tb/test_sid_crc8.sv
module test_sid_crc8;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       clear = 0;
  logic       mode_check = 0;
  logic       bit_valid = 0;
  logic       bit_in = 0;
  logic       bit_ready;
  logic [7:0] crc_value;
  logic       run_done;
  logic       id_good;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  sid_crc8 i_sid_crc8 (
    .clk(clk), .rst_n(rst_n), .clear(clear), .mode_check(mode_check),
    .bit_valid(bit_valid), .bit_ready(bit_ready), .bit_in(bit_in),
    .crc_value(crc_value), .run_done(run_done), .id_good(id_good)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // MSB-first division by 0x31 on the reflected stream, reflected at the end
  function automatic logic [7:0] ref_crc(input logic [63:0] bits, input int n);
    logic [7:0] r = 8'h00;
    logic [7:0] o;
    for (int k = 0; k < n; k++) begin
      logic top;
      top = r[7] ^ bits[k];
      r = {r[6:0], 1'b0} ^ (top ? 8'h31 : 8'h00);
    end
    for (int k = 0; k < 8; k++) o[k] = r[7-k];
    return o;
  endfunction

  task automatic start(input logic m);
    @(negedge clk);
    clear = 1; mode_check = m; bit_valid = 0;
    @(negedge clk);
    clear = 0;
  endtask

  task automatic send(input logic b, input int gap);
    for (int g = 0; g < gap; g++) begin
      bit_valid = 0;
      @(negedge clk);
    end
    bit_valid = 1; bit_in = b;
    @(negedge clk);
    bit_valid = 0;
  endtask

  task automatic send_stream(input logic [63:0] bits, input int n, input int gapmod);
    for (int k = 0; k < n; k++) send(bits[k], (gapmod != 0 && k % gapmod == 0) ? 2 : 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [63:0] id;
    logic [7:0]  c, held;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 crc", crc_value, 0);
    chk("R1 done", run_done, 0);
    chk("R1 good", id_good, 0);
    chk("R1 ready", bit_ready, 1);
    rst_n = 1;
    @(negedge clk);
    chk("R1 ready after release", bit_ready, 1);

    // R2 single steps
    start(0);
    send(1'b1, 0);
    chk("R2 step 1", crc_value, 8'h8C);
    send(1'b0, 0);
    chk("R2 step 0", crc_value, 8'h46);
    // R9 idle cycles keep state
    repeat (3) @(negedge clk);
    chk("R9 hold crc", crc_value, 8'h46);
    chk("R9 hold done", run_done, 0);

    // R8 clear beats a simultaneous bit, captures mode
    @(negedge clk);
    clear = 1; mode_check = 1; bit_valid = 1; bit_in = 1;
    @(negedge clk);
    clear = 0; bit_valid = 0;
    chk("R8 clear zeros", crc_value, 0);
    send_stream(64'h0, 63, 0);
    chk("R8 check mode not done at 63", run_done, 0);
    send(1'b0, 0);
    chk("R8 check mode captured", run_done, 1);
    chk("R5 all-zero id good", id_good, 1);

    // Sweep every family code
    for (int f = 0; f < 256; f++) begin
      logic [47:0] ser;
      ser = 48'h5A3C96E1F00D ^ {6{f[7:0]}} ^ (48'(f) << 17);
      id = {8'h00, ser, f[7:0]};
      c = ref_crc(id, 56);

      // R3/R4 generate
      start(0);
      send_stream(id, 55, (f % 3 == 0) ? 7 : 0);
      chk("R4 not done at 55", run_done, 0);
      send(id[55], 0);
      chk("R4 done at 56", run_done, 1);
      chk("R3 crc value", crc_value, c);
      chk("R7 no good in generate", id_good, 0);
      // R6 offered bits ignored
      if (f % 16 == 0) begin
        held = crc_value;
        chk("R6 ready low", bit_ready, 0);
        send(~held[0], 0);
        send(held[0], 0);
        chk("R6 crc unchanged", crc_value, held);
        chk("R6 still done", run_done, 1);
      end

      // R5 check good
      id[63:56] = c;
      start(1);
      send_stream(id, 63, (f % 4 == 1) ? 5 : 0);
      chk("R5 not done at 63", run_done, 0);
      send(id[63], 0);
      chk("R5 done at 64", run_done, 1);
      chk("R5 residue zero", crc_value, 0);
      chk("R7 good", id_good, 1);

      // R5 single-bit error
      id[f % 64] = ~id[f % 64];
      start(1);
      send_stream(id, 64, 0);
      chk("R5 corrupt done", run_done, 1);
      chk("R5 corrupt residue nonzero", (crc_value != 0), 1);
      chk("R7 corrupt not good", id_good, 0);
    end

    // R7 zero CRC in generate mode still not good
    start(0);
    send_stream(64'h0, 56, 0);
    chk("R7 gen zero crc", crc_value, 0);
    chk("R7 gen zero not good", id_good, 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule